// File: doc/BRIEF.md
# Banked General and Control Register File

This block is the architectural register store of a small 32-bit RISC core. It has sixteen general register numbers. Numbers 0 to 7 have two physical copies, called bank 0 and bank 1. Numbers 8 to 15 have one copy that both banks share. Two combinational read ports and one synchronous write port serve the general registers. A separate selector port reads and writes the system registers: a multiply-accumulate high/low pair and a procedure register. The same port reads and writes five control registers: status, global base, saved status, saved PC and vector base. The program counter has its own load port and read port.

Every access decodes the bank and checks privilege from two bits of the status register. The mode bit is bit 30, where 1 means privileged and 0 means user. The bank bit is bit 29. In user mode only the global base register is reachable among the control registers. Any other control access from user mode is refused, and the block raises a one-cycle violation pulse. The core's exception logic consumes that pulse.

Top module: `bank_regfile`

## Requirements
- R1: A general write (wrEn high) stores wrData into register wrAddr at the clock edge, and both read ports return it on later cycles. Registers 8 to 15 are one copy seen identically from either bank.
- R2: For registers 0 to 7 the bank is chosen as follows. In user mode (status bit 30 = 0), bank 0 is used whatever status bit 29 holds. In privileged mode (bit 30 = 1), bit 29 picks the bank (0 = bank 0, 1 = bank 1).
- R3: A write to the status register changes bank selection only from the cycle after the write. Reads in the cycle of the write still use the old bank.
- R4: The system registers (selector 5 = MAC high, 6 = MAC low, 7 = procedure) can be written and read back in both modes without a violation.
- R5: The global base register (selector 1) can be written and read back in user mode without a violation.
- R6: In user mode, an access (sysEn high) with selector 0 (status), 2 (saved status), 3 (saved PC) or 4 (vector base) writes nothing and reads zero. privFault is high in the cycle after each such access and low after any cycle without one.
- R7: pcWr loads pcWrData as the current instruction address. From the next cycle, pcOut shows that address plus 4.
- R8: Synchronous reset (rst high) clears every register to zero, except the status register, which becomes 0x6000_0000 (privileged, bank 1). privFault reads low and pcOut reads 4.
- R9: When a general write and a read address the same register in the same cycle, the read port returns the new wrData in that cycle.
- R10: In privileged mode all five control registers can be written and read back with no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rdAddrA | input | 4 | Read port A register number |
| rdDataA | output | 32 | Read port A data (combinational) |
| rdAddrB | input | 4 | Read port B register number |
| rdDataB | output | 32 | Read port B data (combinational) |
| wrEn | input | 1 | General register write enable |
| wrAddr | input | 4 | General register write number |
| wrData | input | 32 | General register write data |
| sysEn | input | 1 | System/control access request |
| sysWr | input | 1 | 1 = write, 0 = read, when sysEn is high |
| sysSel | input | 3 | System/control register selector |
| sysWrData | input | 32 | System/control write data |
| sysRdData | output | 32 | System/control read data, zero when refused or idle |
| pcWr | input | 1 | Load the current instruction address |
| pcWrData | input | 32 | Instruction address to load |
| pcOut | output | 32 | Current instruction address plus 4 |
| privFault | output | 1 | One-cycle privilege violation pulse |

## Verification
The bank decode is tested by writing register 2 in bank 1 and in bank 0 with different values. The bench then reads it under privileged bank 1, privileged bank 0 and user mode with the bank bit set. These cases distinguish a decode that ignores the mode from one that ignores the bank bit. Register 9 is read alongside register 2 every time, which separates the shared upper registers from the banked lower ones. A same-cycle write and read of one register tells the bypass apart from a plain array read. The cycle of a status write is sampled separately from the cycle after it, to expose an early bank switch. In user mode, a status write that would return to privileged bank 1 is followed by a read of register 2. That read shows whether the refused write leaked into state. A global base access is set against a saved PC access to show that only the intended control register is exempt from the check.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  // Status register bit positions that the access decode depends on
  localparam int MODE_BIT = 30;
  localparam int BANK_BIT = 29;

  typedef enum logic [2:0] {
    SEL_SR   = 3'd0,
    SEL_GBR  = 3'd1,
    SEL_SSR  = 3'd2,
    SEL_SPC  = 3'd3,
    SEL_VBR  = 3'd4,
    SEL_MACH = 3'd5,
    SEL_MACL = 3'd6,
    SEL_PR   = 3'd7
  } sys_sel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic bankHi;   // low registers use the second copy
    logic gprWe;    // general write this cycle
    logic sysWe;    // permitted system/control write
    logic sysRdOk;  // permitted system/control read
    logic fault;    // refused access this cycle
  } rf_strobe_t;
endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       modeBit,
  input  logic       bankBit,
  input  logic       wrEn,
  input  logic       sysEn,
  input  logic       sysWr,
  input  logic [2:0] sysSel,
  output rf_strobe_t strobe,
  output logic       privFault
);
  logic guardedSel;
  logic blocked;

  always_comb begin
    guardedSel = (sysSel == SEL_SR) || (sysSel == SEL_SSR) ||
                 (sysSel == SEL_SPC) || (sysSel == SEL_VBR);
    blocked    = !modeBit && guardedSel;

    strobe.bankHi  = modeBit && bankBit;
    strobe.gprWe   = wrEn;
    strobe.sysWe   = sysEn && sysWr && !blocked;
    strobe.sysRdOk = sysEn && !blocked;
    strobe.fault   = sysEn && blocked;
  end

  always_ff @(posedge clk) begin
    if (rst) privFault <= 1'b0;
    else     privFault <= strobe.fault;
  end

  // R6: a violation pulse always traces back to a user access of a guarded selector
  p_fault_source_r6: assert property (@(posedge clk) disable iff (rst)
    privFault |-> $past(sysEn && !modeBit && sysSel != SEL_GBR && sysSel < SEL_MACH));

  // R4: system registers never raise a violation
  p_sys_free_r4: assert property (@(posedge clk) disable iff (rst)
    (sysEn && sysSel >= SEL_MACH) |=> !privFault);
endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_BANKED = 8,
  localparam int NUM_GPR = 2 * NUM_BANKED,
  localparam int GA = $clog2(NUM_GPR),
  localparam int LA = $clog2(NUM_BANKED)
) (
  input  logic              clk,
  input  logic              rst,
  input  rf_strobe_t        strobe,
  input  logic [GA-1:0]     rdAddrA,
  input  logic [GA-1:0]     rdAddrB,
  input  logic [GA-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        sysSel,
  input  logic [DATA_W-1:0] sysWrData,
  input  logic              pcWr,
  input  logic [DATA_W-1:0] pcWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] sysRdData,
  output logic [DATA_W-1:0] pcOut,
  output logic              srMode,
  output logic              srBank
);
  localparam logic [DATA_W-1:0] SR_RESET =
    (DATA_W'(1) << MODE_BIT) | (DATA_W'(1) << BANK_BIT);

  logic [DATA_W-1:0] bank0Arr [NUM_BANKED];
  logic [DATA_W-1:0] bank1Arr [NUM_BANKED];
  logic [DATA_W-1:0] upperArr [NUM_BANKED];
  logic [DATA_W-1:0] sysQ     [8];
  logic [DATA_W-1:0] pcQ;

  // One slice per low register number: two banked copies plus the shared upper partner
  for (genvar g = 0; g < NUM_BANKED; g++) begin : g_slot
    logic [DATA_W-1:0] b0q, b1q, upq;
    logic hitLow, hitUp;
    assign hitLow = strobe.gprWe && !wrAddr[LA] && (wrAddr[LA-1:0] == LA'(g));
    assign hitUp  = strobe.gprWe &&  wrAddr[LA] && (wrAddr[LA-1:0] == LA'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        b0q <= '0;
        b1q <= '0;
        upq <= '0;
      end else begin
        if (hitLow && !strobe.bankHi) b0q <= wrData;
        if (hitLow &&  strobe.bankHi) b1q <= wrData;
        if (hitUp)                    upq <= wrData;
      end
    end
    assign bank0Arr[g] = b0q;
    assign bank1Arr[g] = b1q;
    assign upperArr[g] = upq;
  end

  function automatic logic [DATA_W-1:0] readGpr(input logic [GA-1:0] a);
    if (strobe.gprWe && wrAddr == a) return wrData;
    if (a[LA])                       return upperArr[a[LA-1:0]];
    if (strobe.bankHi)               return bank1Arr[a[LA-1:0]];
    return bank0Arr[a[LA-1:0]];
  endfunction

  assign rdDataA = readGpr(rdAddrA);
  assign rdDataB = readGpr(rdAddrB);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) sysQ[i] <= (i == 0) ? SR_RESET : '0;
      pcQ <= '0;
    end else begin
      if (strobe.sysWe) sysQ[sysSel] <= sysWrData;
      if (pcWr)         pcQ <= pcWrData;
    end
  end

  assign sysRdData = strobe.sysRdOk ? sysQ[sysSel] : '0;
  assign pcOut     = pcQ + DATA_W'(4);
  assign srMode    = sysQ[SEL_SR][MODE_BIT];
  assign srBank    = sysQ[SEL_SR][BANK_BIT];

  // R6: user mode can never write its way back to privileged mode
  p_user_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    !srMode |=> !srMode);

  // R7: a loaded address appears plus four on the next cycle
  p_pc_step_r7: assert property (@(posedge clk) disable iff (rst)
    pcWr |=> pcOut == $past(pcWrData) + DATA_W'(4));

  // R1: a written register reads back next cycle when the bank and address are unchanged
  p_write_lands_r1: assert property (@(posedge clk) disable iff (rst)
    strobe.gprWe |=> (!(rdAddrA == $past(wrAddr) && strobe.bankHi == $past(strobe.bankHi) &&
                        !(strobe.gprWe && wrAddr == rdAddrA)) || rdDataA == $past(wrData)));
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import regfile_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_BANKED = 8,
  localparam int GA = $clog2(2 * NUM_BANKED)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [GA-1:0]     rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [GA-1:0]     rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [GA-1:0]     wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sysEn,
  input  logic              sysWr,
  input  logic [2:0]        sysSel,
  input  logic [DATA_W-1:0] sysWrData,
  output logic [DATA_W-1:0] sysRdData,
  input  logic              pcWr,
  input  logic [DATA_W-1:0] pcWrData,
  output logic [DATA_W-1:0] pcOut,
  output logic              privFault
);
  rf_strobe_t strobe;
  logic srMode, srBank;

  regfile_ctrl u_ctrl (
    .clk(clk), .rst(rst), .modeBit(srMode), .bankBit(srBank),
    .wrEn(wrEn), .sysEn(sysEn), .sysWr(sysWr), .sysSel(sysSel),
    .strobe(strobe), .privFault(privFault)
  );

  regfile_dp #(.DATA_W(DATA_W), .NUM_BANKED(NUM_BANKED)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .wrAddr(wrAddr), .wrData(wrData),
    .sysSel(sysSel), .sysWrData(sysWrData), .pcWr(pcWr), .pcWrData(pcWrData),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .sysRdData(sysRdData), .pcOut(pcOut),
    .srMode(srMode), .srBank(srBank)
  );
endmodule

// File: tb/sim_bank_regfile.sv
`timescale 1ns/1ps
module sim_bank_regfile;
  import regfile_pkg::*;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        rst;
  logic [3:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData;
  logic        wrEn, sysEn, sysWr, pcWr, privFault;
  logic [2:0]  sysSel;
  logic [31:0] sysWrData, sysRdData, pcWrData, pcOut;

  bank_regfile u0 (
    .clk(clk), .rst(rst), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .sysEn(sysEn), .sysWr(sysWr), .sysSel(sysSel),
    .sysWrData(sysWrData), .sysRdData(sysRdData), .pcWr(pcWr),
    .pcWrData(pcWrData), .pcOut(pcOut), .privFault(privFault)
  );

  localparam int K_RDA = 0, K_RDB = 1, K_SYS = 2, K_PC = 3, K_FLT = 4;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic want(int kind, logic [31:0] exp, string tag, int lag);
    item_t it;
    it.due = cyc + lag; it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  function automatic logic [31:0] pick(int kind);
    case (kind)
      K_RDA:   return rdDataA;
      K_RDB:   return rdDataB;
      K_SYS:   return sysRdData;
      K_PC:    return pcOut;
      default: return {31'b0, privFault};
    endcase
  endfunction

  // Monitor: compare every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        logic [31:0] act;
        act = pick(sb[i].kind);
        total++;
        if (act !== sb[i].exp) begin
          bad++;
          $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                   sb[i].tag, sb[i].kind, cyc, act, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    wrEn = 0; sysEn = 0; sysWr = 0; pcWr = 0;
  endtask

  task automatic gw(logic [3:0] a, logic [31:0] d);
    wrEn = 1; wrAddr = a; wrData = d; tick(); idle();
  endtask

  task automatic rdAB(logic [3:0] a, logic [31:0] ea, string ta,
                      logic [3:0] b, logic [31:0] eb, string tb);
    rdAddrA = a; rdAddrB = b;
    want(K_RDA, ea, ta, 0); want(K_RDB, eb, tb, 0);
    tick();
  endtask

  task automatic sw(logic [2:0] s, logic [31:0] d, logic f, string tag);
    sysEn = 1; sysWr = 1; sysSel = s; sysWrData = d;
    want(K_FLT, {31'b0, f}, tag, 1);
    tick(); idle();
  endtask

  task automatic sr(logic [2:0] s, logic [31:0] e, logic f, string tag);
    sysEn = 1; sysWr = 0; sysSel = s;
    want(K_SYS, e, tag, 0); want(K_FLT, {31'b0, f}, tag, 1);
    tick(); idle();
  endtask

  task automatic doReset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic finishUp();
    if (sb.size() != 0) begin
      total += sb.size(); bad += sb.size();
      $display("FAIL unchecked items remain: actual=%0d expected=0", sb.size());
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(); rdAddrA = 0; rdAddrB = 0; wrAddr = 0; wrData = 0;
    sysSel = 0; sysWrData = 0; pcWrData = 0;
    doReset();

    // R8: reset state
    rdAddrA = 3; rdAddrB = 12;
    want(K_RDA, 0, "R8", 0); want(K_RDB, 0, "R8", 0);
    want(K_PC, 32'd4, "R8", 0); want(K_FLT, 0, "R8", 0);
    sr(SEL_SR, 32'h6000_0000, 0, "R8");

    // Privileged, bank 1
    gw(2, 32'h11);
    gw(9, 32'h99);

    // R10: privileged control access
    sw(SEL_VBR, 32'h8000, 0, "R10");
    sr(SEL_VBR, 32'h8000, 0, "R10");
    sw(SEL_SSR, 32'h1234, 0, "R10");
    sr(SEL_SSR, 32'h1234, 0, "R10");

    // R3: the switch to bank 0 takes effect only after the write cycle
    rdAddrA = 2; want(K_RDA, 32'h11, "R3", 0);
    sw(SEL_SR, 32'h4000_0000, 0, "R3");
    rdAB(2, 32'h0, "R2", 9, 32'h99, "R1");

    gw(2, 32'h22);

    // R9: same-cycle write and read
    wrEn = 1; wrAddr = 5; wrData = 32'h55; rdAddrA = 5; rdAddrB = 5;
    want(K_RDA, 32'h55, "R9", 0); want(K_RDB, 32'h55, "R9", 0);
    tick(); idle();
    rdAB(5, 32'h55, "R1", 2, 32'h22, "R1");

    // R2: back to privileged bank 1
    sw(SEL_SR, 32'h6000_0000, 0, "R2");
    rdAB(2, 32'h11, "R2", 9, 32'h99, "R1");

    // R7: program counter
    pcWr = 1; pcWrData = 32'h0000_1000; tick(); idle();
    want(K_PC, 32'h0000_1004, "R7", 0); tick();

    // R4: system register in privileged mode
    sw(SEL_MACL, 32'hCAFE, 0, "R4");
    sr(SEL_MACL, 32'hCAFE, 0, "R4");

    // R2: user mode with bank bit set still uses bank 0
    sw(SEL_SR, 32'h2000_0000, 0, "R2");
    rdAB(2, 32'h22, "R2", 9, 32'h99, "R1");
    gw(2, 32'h77);
    rdAB(2, 32'h77, "R2", 9, 32'h99, "R1");

    // R6: refused user accesses
    sw(SEL_SR, 32'h6000_0000, 1, "R6");
    rdAB(2, 32'h77, "R6", 9, 32'h99, "R6");   // SR unchanged: still user bank 0
    sr(SEL_SR, 32'h0, 1, "R6");
    sr(SEL_SPC, 32'h0, 1, "R6");
    want(K_FLT, 0, "R6", 1); tick();
    sw(SEL_VBR, 32'hDEAD, 1, "R6");
    sr(SEL_SSR, 32'h0, 1, "R6");

    // R5: global base in user mode
    sw(SEL_GBR, 32'hABCD, 0, "R5");
    sr(SEL_GBR, 32'hABCD, 0, "R5");

    // R4: system registers in user mode
    sw(SEL_MACH, 32'h1111, 0, "R4");
    sr(SEL_MACH, 32'h1111, 0, "R4");
    sw(SEL_PR, 32'h2222, 0, "R4");
    sr(SEL_PR, 32'h2222, 0, "R4");
    sr(SEL_MACL, 32'hCAFE, 0, "R4");

    // R8: reset again clears everything and returns to privileged bank 1
    doReset();
    rdAddrA = 2; rdAddrB = 9;
    want(K_RDA, 0, "R8", 0); want(K_RDB, 0, "R8", 0); want(K_PC, 32'd4, "R8", 0);
    sr(SEL_SR, 32'h6000_0000, 0, "R8");
    sr(SEL_GBR, 32'h0, 0, "R8");
    sr(SEL_VBR, 32'h0, 0, "R8");
    tick(); tick();

    done = 1;
    finishUp();
  end
endmodule